// File: doc/BRIEF.md
# Latched Interval Timer

A byte-addressed down-counting interval timer with a reload latch, two counter-width bytes wide. Software sets the reload value one byte at a time. Writing the counter's high byte completes the latch, copies the whole latch into the counter and arms an expiry. The counter moves only on cycles where the `tick` clock-enable is high. When it steps from zero to all-ones, the timer signals an expiry: a one-cycle `t1_expire` pulse, and a sticky `t1_flag` that stays up until software clears it. Reads return the live counter bytes or the latch bytes.

Bit 6 of the control input `ctrl` selects the mode. In free-running mode, the cycle after the all-ones state reloads the counter from the latch, so the counter repeats with a period of latch+2 ticks. In one-shot mode, the timer fires once per load and then keeps counting down past all-ones without reloading. A second, simpler timer can be included with the parameter `HAS_T2`. It has only counter-low and counter-high byte access and always behaves as one-shot.

Each timer is a state machine with three states:
- `ST_SPENT`: counting with no expiry pending. This is the reset state and the state after a one-shot fires.
- `ST_ARMED`: counting, and the next zero crossing fires.
- `ST_WRAP`: free-running mode after an expiry, with the counter at all-ones. The next tick reloads it.

The transitions are:
- *load*: a counter-high write, from any state to `ST_ARMED`.
- *fire-once*: `ST_ARMED` to `ST_SPENT` on a one-shot zero crossing.
- *fire-wrap*: `ST_ARMED` or `ST_SPENT` to `ST_WRAP` on a free-running zero crossing.
- *reload*: `ST_WRAP` to `ST_ARMED` on the next tick while free-running.
- *drop*: `ST_WRAP` to `ST_SPENT` on the next tick in one-shot mode.

Top module: `lit_timer_top`

## Requirements
- R1: The counter changes only on cycles with `tick` high. On a tick it decrements, and from 0x0000 it goes to 0xFFFF. In free-running mode (`ctrl` bit 6 = 1), the tick after that 0xFFFF reloads the latch. Expiries then repeat every latch+2 ticks.
- R2: A tick that takes the counter from 0x0000 to 0xFFFF, while armed or free-running, raises the expiry pulse for exactly the next cycle. It sets the flag at the same edge.
- R3: A write to address 4 replaces only the low latch byte. The running counter keeps its value.
- R4: A write to address 5 replaces the high latch byte, loads the counter with the full latch, clears timer 1's flag and arms the timer.
- R5: A write to address 7 replaces the high latch byte and clears the flag, without changing the counter. A write to address 6 replaces only the low latch byte.
- R6: A read with `rd_en` at address 4 clears timer 1's flag. A read at address 5 leaves the flag unchanged.
- R7: In one-shot mode (`ctrl` bit 6 = 0), a load produces exactly one expiry. After it, the counter keeps decrementing from 0xFFFF without reloading.
- R8: After reset, both timers' latch and counter are 0xFFFF, both flags and pulses are low, and no load is pending.
- R9: Timer 2, when present, works as follows. A write to address 8 sets its low latch byte. A write to address 9 sets its high latch byte, loads its counter from the latch and clears its flag. It ignores `ctrl` bit 6, so it is always one-shot. Reading address 8 with `rd_en` clears its flag.
- R10: `rdata` shows the addressed byte combinationally, as follows:
  - address 4: counter low byte
  - address 5: counter high byte
  - address 6: latch low byte
  - address 7: latch high byte
  - addresses 8 and 9: timer 2 counter low and high bytes
  - any other address: 0x00
- R11: If an expiry and a flag-clearing read happen in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count enable for both timers |
| ctrl | input | 8 | Control byte; bit 6 selects free-running mode for timer 1 |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (read side effects) |
| addr | input | 4 | Register byte address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| t1_expire | output | 1 | Timer 1 expiry pulse |
| t1_flag | output | 1 | Timer 1 sticky interrupt flag |
| t2_expire | output | 1 | Timer 2 expiry pulse |
| t2_flag | output | 1 | Timer 2 sticky interrupt flag |

## Verification
The assertions check the following on every cycle:
- each zero crossing leads to all-ones;
- a load makes the counter equal the latch and clears the flag;
- a low-byte or latch-high write leaves a stalled counter alone;
- an expiry always shows together with a set flag;
- a spent one-shot timer never pulses.

The bench scenarios cover what spans many cycles or needs the whole address map: the exact latch+2 spacing of free-running expiries, the byte values seen through `rdata`, which reads clear the flag and which do not, the same-cycle set-versus-clear case, and timer 2 ignoring the mode bit.

// File: rtl/lit_pkg.sv
package lit_pkg;

    typedef enum logic [1:0] {
        ST_SPENT = 2'd0,
        ST_ARMED = 2'd1,
        ST_WRAP  = 2'd2
    } tmr_state_e;

    typedef struct packed {
        logic cnt_lo_wr;
        logic cnt_hi_wr;
        logic lat_lo_wr;
        logic lat_hi_wr;
        logic cnt_lo_rd;
    } tmr_strobe_t;

    localparam int T1_CNT_LO = 4;
    localparam int T1_CNT_HI = 5;
    localparam int T1_LAT_LO = 6;
    localparam int T1_LAT_HI = 7;
    localparam int T2_CNT_LO = 8;
    localparam int T2_CNT_HI = 9;

    localparam int FREE_RUN_BIT = 6;

endpackage

// File: rtl/lit_decode.sv
module lit_decode
    import lit_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter logic [ADDR_W-1:0] OFS_CNT_LO = '0,
    parameter logic [ADDR_W-1:0] OFS_CNT_HI = '0,
    parameter logic [ADDR_W-1:0] OFS_LAT_LO = '0,
    parameter logic [ADDR_W-1:0] OFS_LAT_HI = '0,
    parameter bit HAS_LATCH_REGS = 1'b1
) (
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    output tmr_strobe_t       stb
);

    always_comb begin
        stb.cnt_lo_wr = wr_en && (addr == OFS_CNT_LO);
        stb.cnt_hi_wr = wr_en && (addr == OFS_CNT_HI);
        stb.cnt_lo_rd = rd_en && (addr == OFS_CNT_LO);
    end

    generate
        if (HAS_LATCH_REGS) begin : g_latch_regs
            always_comb begin
                stb.lat_lo_wr = wr_en && (addr == OFS_LAT_LO);
                stb.lat_hi_wr = wr_en && (addr == OFS_LAT_HI);
            end
        end else begin : g_no_latch_regs
            always_comb begin
                stb.lat_lo_wr = 1'b0;
                stb.lat_hi_wr = 1'b0;
            end
        end
    endgenerate

endmodule

// File: rtl/lit_timer_core.sv
module lit_timer_core
    import lit_pkg::*;
#(
    parameter int BYTE_W      = 8,
    parameter bit FREE_RUN_OK = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic                free_sel,
    input  tmr_strobe_t         stb,
    input  logic [BYTE_W-1:0]   wdata,
    output logic [2*BYTE_W-1:0] cnt,
    output logic [2*BYTE_W-1:0] latch,
    output logic                flag,
    output logic                expire
);

    localparam int CNT_W = 2 * BYTE_W;
    localparam logic [CNT_W-1:0] ALL_ONES = {CNT_W{1'b1}};

    tmr_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] latch_q, latch_d;
    logic             flag_q, expire_q;
    logic             free, zero_hit, fire, flag_clr;

    assign free     = FREE_RUN_OK && free_sel;
    assign zero_hit = tick && (cnt_q == '0) && !stb.cnt_hi_wr;
    assign fire     = zero_hit && ((state_q == ST_ARMED) || free);
    assign flag_clr = stb.cnt_hi_wr || stb.lat_hi_wr || stb.cnt_lo_rd;

    // latch byte updates
    always_comb begin
        latch_d = latch_q;
        if (stb.cnt_lo_wr || stb.lat_lo_wr)
            latch_d[BYTE_W-1:0] = wdata;
        if (stb.cnt_hi_wr || stb.lat_hi_wr)
            latch_d[CNT_W-1:BYTE_W] = wdata;
    end

    // next state and next count
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (stb.cnt_hi_wr) begin
            state_d = ST_ARMED;
            cnt_d   = {wdata, latch_q[BYTE_W-1:0]};
        end else if (tick) begin
            cnt_d = cnt_q - 1'b1;
            unique case (state_q)
                ST_ARMED: begin
                    if (cnt_q == '0)
                        state_d = free ? ST_WRAP : ST_SPENT;
                end
                ST_SPENT: begin
                    if ((cnt_q == '0) && free)
                        state_d = ST_WRAP;
                end
                ST_WRAP: begin
                    if (free) begin
                        cnt_d   = latch_q;
                        state_d = ST_ARMED;
                    end else begin
                        state_d = ST_SPENT;
                    end
                end
                default: state_d = ST_SPENT;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_SPENT;
            cnt_q   <= ALL_ONES;
            latch_q <= ALL_ONES;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            latch_q <= latch_d;
        end
    end

    // event outputs: a new expiry wins over a same-cycle clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q   <= 1'b0;
            expire_q <= 1'b0;
        end else begin
            expire_q <= fire;
            if (fire)
                flag_q <= 1'b1;
            else if (flag_clr)
                flag_q <= 1'b0;
        end
    end

    assign cnt    = cnt_q;
    assign latch  = latch_q;
    assign flag   = flag_q;
    assign expire = expire_q;

    AST_ZERO_TO_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && (cnt_q == '0) && !stb.cnt_hi_wr) |=> (cnt_q == ALL_ONES)); // R1
    AST_EXPIRE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        expire_q |-> flag_q); // R2
    AST_LO_WRITE_KEEPS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (stb.cnt_lo_wr && !tick) |=> (cnt_q == $past(cnt_q))); // R3
    AST_LOAD_COPIES_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        stb.cnt_hi_wr |=> ((cnt_q == latch_q) && !flag_q && !expire_q)); // R4
    AST_LATCH_HI_NO_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (stb.lat_hi_wr && !tick) |=> ((cnt_q == $past(cnt_q)) && !flag_q)); // R5
    AST_ONESHOT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_SPENT) && !free && !stb.cnt_hi_wr) |=> !expire_q); // R7
    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && stb.cnt_lo_rd) |=> (flag_q && expire_q)); // R11

endmodule

// File: rtl/lit_timer_top.sv
module lit_timer_top
    import lit_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int ADDR_W = 4,
    parameter bit HAS_T2 = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [BYTE_W-1:0] ctrl,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    output logic              t1_expire,
    output logic              t1_flag,
    output logic              t2_expire,
    output logic              t2_flag
);

    localparam int CNT_W = 2 * BYTE_W;
    localparam logic [ADDR_W-1:0] A_T1_LO  = ADDR_W'(T1_CNT_LO);
    localparam logic [ADDR_W-1:0] A_T1_HI  = ADDR_W'(T1_CNT_HI);
    localparam logic [ADDR_W-1:0] A_T1_LLO = ADDR_W'(T1_LAT_LO);
    localparam logic [ADDR_W-1:0] A_T1_LHI = ADDR_W'(T1_LAT_HI);
    localparam logic [ADDR_W-1:0] A_T2_LO  = ADDR_W'(T2_CNT_LO);
    localparam logic [ADDR_W-1:0] A_T2_HI  = ADDR_W'(T2_CNT_HI);

    tmr_strobe_t      t1_stb;
    logic [CNT_W-1:0] t1_cnt, t1_latch;
    logic [CNT_W-1:0] t2_cnt;

    lit_decode #(
        .ADDR_W(ADDR_W), .OFS_CNT_LO(A_T1_LO), .OFS_CNT_HI(A_T1_HI),
        .OFS_LAT_LO(A_T1_LLO), .OFS_LAT_HI(A_T1_LHI), .HAS_LATCH_REGS(1'b1)
    ) u_t1_dec (
        .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .stb(t1_stb)
    );

    lit_timer_core #(.BYTE_W(BYTE_W), .FREE_RUN_OK(1'b1)) u_t1 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .free_sel(ctrl[FREE_RUN_BIT]),
        .stb(t1_stb), .wdata(wdata), .cnt(t1_cnt), .latch(t1_latch),
        .flag(t1_flag), .expire(t1_expire)
    );

    generate
        if (HAS_T2) begin : g_t2
            tmr_strobe_t      t2_stb;
            logic [CNT_W-1:0] t2_latch_unused;

            lit_decode #(
                .ADDR_W(ADDR_W), .OFS_CNT_LO(A_T2_LO), .OFS_CNT_HI(A_T2_HI),
                .OFS_LAT_LO(A_T2_LO), .OFS_LAT_HI(A_T2_HI), .HAS_LATCH_REGS(1'b0)
            ) u_t2_dec (
                .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .stb(t2_stb)
            );

            lit_timer_core #(.BYTE_W(BYTE_W), .FREE_RUN_OK(1'b0)) u_t2 (
                .clk(clk), .rst_n(rst_n), .tick(tick), .free_sel(ctrl[FREE_RUN_BIT]),
                .stb(t2_stb), .wdata(wdata), .cnt(t2_cnt), .latch(t2_latch_unused),
                .flag(t2_flag), .expire(t2_expire)
            );
        end else begin : g_no_t2
            assign t2_cnt    = '0;
            assign t2_flag   = 1'b0;
            assign t2_expire = 1'b0;
        end
    endgenerate

    // read data: live counter and latch bytes
    always_comb begin
        rdata = '0;
        if (addr == A_T1_LO)
            rdata = t1_cnt[BYTE_W-1:0];
        else if (addr == A_T1_HI)
            rdata = t1_cnt[CNT_W-1:BYTE_W];
        else if (addr == A_T1_LLO)
            rdata = t1_latch[BYTE_W-1:0];
        else if (addr == A_T1_LHI)
            rdata = t1_latch[CNT_W-1:BYTE_W];
        else if (HAS_T2 && (addr == A_T2_LO))
            rdata = t2_cnt[BYTE_W-1:0];
        else if (HAS_T2 && (addr == A_T2_HI))
            rdata = t2_cnt[CNT_W-1:BYTE_W];
    end

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (addr < A_T1_LO) |-> (rdata == '0)); // R10

endmodule

// File: tb/tb_lit_timer_top.sv
module tb_lit_timer_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic [7:0] ctrl = 8'h00;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [3:0] addr = 4'h0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       t1_expire, t1_flag, t2_expire, t2_flag;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    lit_timer_top dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .ctrl(ctrl), .wr_en(wr_en),
        .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata),
        .t1_expire(t1_expire), .t1_flag(t1_flag),
        .t2_expire(t2_expire), .t2_flag(t2_flag)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic peek(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b0;
        #1 d = rdata;
    endtask

    task automatic rd_clr(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic peek16(input logic [3:0] lo, output int v);
        logic [7:0] l, h;
        peek(lo, l);
        peek(lo + 4'd1, h);
        v = {h, l};
    endtask

    task automatic ticks(input int n, output int n1, output int n2, output int first1);
        n1 = 0; n2 = 0; first1 = 0;
        for (int i = 1; i <= n; i++) begin
            tick = 1'b1;
            @(negedge clk);
            if (t1_expire) begin
                n1++;
                if (first1 == 0) first1 = i;
            end
            if (t2_expire) n2++;
        end
        tick = 1'b0;
    endtask

    task automatic t_reset();
        int v;
        peek16(4'd4, v); chk("R8 t1 counter", v, 16'hFFFF);
        peek16(4'd6, v); chk("R8 t1 latch", v, 16'hFFFF);
        peek16(4'd8, v); chk("R8 t2 counter", v, 16'hFFFF);
        chk("R8 flags", {t1_flag, t2_flag, t1_expire, t2_expire}, 0);
    endtask

    task automatic t_map();
        logic [7:0] d;
        int v;
        peek(4'd0, d); chk("R10 unmapped addr 0", d, 0);
        peek(4'd15, d); chk("R10 unmapped addr 15", d, 0);
        wr(4'd4, 8'h34);
        peek16(4'd4, v); chk("R3 counter kept", v, 16'hFFFF);
        peek(4'd6, d); chk("R3 latch low", d, 8'h34);
        wr(4'd5, 8'h00);
        peek16(4'd4, v); chk("R4 counter loaded", v, 16'h0034);
        peek(4'd7, d); chk("R10 latch high", d, 8'h00);
        repeat (5) @(negedge clk);
        peek16(4'd4, v); chk("R1 no tick no count", v, 16'h0034);
    endtask

    task automatic t_free_run();
        int n1, n2, f1, v;
        ctrl = 8'h40;
        wr(4'd4, 8'h03);
        wr(4'd5, 8'h00);
        ticks(4, n1, n2, f1);
        chk("R2 first expiry tick", f1, 4);
        chk("R2 flag set", t1_flag, 1);
        peek16(4'd4, v); chk("R1 zero to FFFF", v, 16'hFFFF);
        ticks(5, n1, n2, f1);
        chk("R1 period latch+2", f1, 5);
        chk("R1 one expiry per period", n1, 1);
        ticks(3, n1, n2, f1);
        peek16(4'd4, v); chk("R1 reloaded and counting", v, 16'h0001);
        ctrl = 8'h00;
    endtask

    task automatic t_one_shot();
        int n1, n2, f1, v;
        logic [7:0] d;
        wr(4'd4, 8'h02);
        wr(4'd5, 8'h00);
        chk("R4 flag cleared by load", t1_flag, 0);
        ticks(3, n1, n2, f1);
        chk("R7 single expiry", n1, 1);
        ticks(4, n1, n2, f1);
        chk("R7 no repeat", n1, 0);
        peek16(4'd4, v); chk("R7 no reload", v, 16'hFFFB);
        chk("R7 flag held", t1_flag, 1);
        wr(4'd7, 8'h12);
        chk("R5 flag cleared", t1_flag, 0);
        peek16(4'd4, v); chk("R5 counter kept", v, 16'hFFFB);
        peek16(4'd6, v); chk("R5 latch updated", v, 16'h1202);
        wr(4'd6, 8'h05);
        peek16(4'd6, v); chk("R5 latch low write", v, 16'h1205);
        wr(4'd5, 8'h00);
        ticks(6, n1, n2, f1);
        chk("R4 rearmed expiry", f1, 6);
        rd_clr(4'd5, d);
        chk("R6 high read keeps flag", t1_flag, 1);
        rd_clr(4'd4, d);
        chk("R6 low read clears flag", t1_flag, 0);
    endtask

    task automatic t_set_wins();
        int n1, n2, f1;
        wr(4'd4, 8'h01);
        wr(4'd5, 8'h00);
        ticks(1, n1, n2, f1);
        @(negedge clk);
        tick = 1'b1; rd_en = 1'b1; addr = 4'd4;
        @(negedge clk);
        tick = 1'b0; rd_en = 1'b0;
        chk("R11 expiry pulse", t1_expire, 1);
        chk("R11 flag set over clear", t1_flag, 1);
    endtask

    task automatic t_second();
        int n1, n2, f1, v;
        logic [7:0] d;
        ctrl = 8'h40;
        wr(4'd8, 8'h02);
        wr(4'd9, 8'h00);
        peek16(4'd8, v); chk("R9 t2 load", v, 16'h0002);
        chk("R9 t2 flag clear", t2_flag, 0);
        ticks(3, n1, n2, f1);
        chk("R9 t2 expiry", n2, 1);
        ticks(6, n1, n2, f1);
        chk("R9 t2 always one-shot", n2, 0);
        peek16(4'd8, v); chk("R9 t2 no reload", v, 16'hFFF9);
        rd_clr(4'd8, d);
        chk("R9 t2 read clears flag", t2_flag, 0);
        ctrl = 8'h00;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_map();
        t_free_run();
        t_one_shot();
        t_set_wins();
        t_second();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #800000;
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule